// File: doc/BRIEF.md
# JTAG User-Register Bridge

This block sits behind a user data register of an FPGA's test access port and gives a host a small bank of 32-bit registers, reached with plain DR scans. All logic runs on the test clock. The TAP controller supplies the capture, shift and update strobes and a select that is high while the user instruction is loaded. Bits enter on `tdi` least-significant first and leave on `tdo`. The TAP retimes `tdo` to the falling edge outside this block.

A 38-bit frame writes one register: 32 data bits, 4 address bits, a write flag of 1 and an odd-parity bit. A 6-bit frame asks for a read: 4 address bits, a write flag of 0 and an odd-parity bit. The word it names is latched when Update-DR is reached, and the following DR scan returns it. The bank drives the work words (eight midstate words and three header-tail words) and a clock-speed setting to a hashing core. Writing the last tail word raises a start pulse for new work.

Found nonces come in on a valid/ready stream and are held in a one-entry result slot. A transfer happens on a clock edge where both `nonce_valid` and `nonce_ready` are high. `nonce_ready` is high while the slot is empty, and also in the cycle in which a read of the result register empties it. The core must hold `nonce_valid` and `nonce_data` steady until it is accepted.

Top module: `jtag_reg_bridge`

## Requirements
- R1: A frame of exactly 38 shifted bits is a write: bits 0-31 are data, bits 32-35 are the address (bit 32 is the LSB), bit 36 is 1, and the ones count over all 38 bits is odd. Bit 37 is the parity bit. The addressed register takes the data on the Update-DR edge.
- R2: A 38-bit frame with an even ones count writes nothing and leaves the latched read word unchanged.
- R3: A frame of exactly 6 bits is a read request: bits 0-3 are the address, bit 4 is 0, bit 5 is parity, and the ones count is odd. On the next Capture-DR edge the latched word is loaded, and `tdo` then shows its bit 0. Each Shift-DR edge advances `tdo` to the next bit, so the word comes out least-significant bit first.
- R4: At update time, any other length, a 38-bit frame with bit 36 at 0, or a 6-bit frame with bit 4 at 1 is dropped, just like R2.
- R5: Registers 1 to 8 drive midstate word 0 to 7, at `midstate[32*k +: 32]` for register k+1. Registers 9 to 11 drive `hdr_tail[32*j +: 32]` for register 9+j. All of these read back what was written.
- R6: Register 13 drives `clk_setting` and reads back. Nothing else changes it.
- R7: Register 14 reads 0xFFFFFFFF while the result slot is empty, and otherwise reads the held nonce. A read request of register 14 empties the slot.
- R8: A nonce offered in the same cycle that a read of register 14 empties the slot is accepted and kept. A nonce is never accepted while the slot is full and no read empties it.
- R9: `work_start` is high for exactly the one cycle after the Update-DR edge of a good write to register 11, and is low at all other times.
- R10: Registers 0, 12 and 15, and writes to register 14, have no stored state. The first three read as zero, and writes to any of the four are ignored.
- R11: While `usr_sel` is low, the capture, shift and update strobes have no effect.
- R12: After reset all registers are zero, the slot is empty, `tdo` is 0, `work_start` is 0 and `nonce_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_sel | input | 1 | High while the user instruction is loaded |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in, LSB first |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| nonce_valid | input | 1 | Result stream valid |
| nonce_data | input | 32 | Result stream nonce |
| nonce_ready | output | 1 | Result stream ready |
| midstate | output | 256 | Registers 1-8, word k at bits 32k+31:32k |
| hdr_tail | output | 96 | Registers 9-11 |
| clk_setting | output | 32 | Register 13 |
| work_start | output | 1 | One-cycle pulse after a write to register 11 |

## Verification
A write is visible on `midstate`, `hdr_tail` and `clk_setting` one edge after the Update-DR edge. `work_start` is high in that same cycle and low in the next, and the bench samples both cycles at the falling edge. Read data is due on `tdo` one edge after Capture-DR, and then one new bit after each shift edge. The bench samples `tdo` at each falling edge before raising the next shift, so every sample falls between two active edges. `nonce_ready` is combinational from the slot state and the update strobe, so it is sampled just after the inputs for that cycle are driven, before the edge that would accept the nonce.

// File: rtl/jub_pkg.sv
package jub_pkg;
  localparam int DW       = 32;
  localparam int AW       = 4;
  localparam int WR_LEN   = DW + AW + 2;
  localparam int RD_LEN   = AW + 2;
  localparam int CNT_MAX  = WR_LEN + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int FLAG_POS = DW + AW;
  localparam int N_MID    = 8;
  localparam int N_TAIL   = 3;
  localparam int N_HDR    = N_MID + N_TAIL;
  localparam int A_FIRST  = 1;
  localparam int A_START  = N_HDR;
  localparam int A_CLK    = 13;
  localparam int A_RES    = 14;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } cmd_t;
endpackage

// File: rtl/jub_shifter.sv
module jub_shifter
  import jub_pkg::*;
(
  input  logic              tck,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              sft,
  input  logic              upd,
  input  logic              tdi,
  input  logic [DW-1:0]     load_word,
  output logic [WR_LEN-1:0] sr,
  output logic [CNT_W-1:0]  cnt,
  output logic              tdo
);
  always_ff @(posedge tck) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cap) begin
      sr  <= {{(WR_LEN-DW){1'b0}}, load_word};
      cnt <= '0;
    end else if (sft) begin
      sr  <= {tdi, sr[WR_LEN-1:1]};
      if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end else if (upd) begin
      cnt <= '0;
    end
  end

  assign tdo = sr[0];

  // R4
  cnt_bound_chk: assert property (@(posedge tck) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/jub_decode.sv
module jub_decode
  import jub_pkg::*;
(
  input  logic              upd,
  input  logic [WR_LEN-1:0] sr,
  input  logic [CNT_W-1:0]  cnt,
  output cmd_t              cmd
);
  localparam int RD_BASE = WR_LEN - RD_LEN;

  logic len_wr, len_rd, par_wr, par_rd;

  always_comb begin
    len_wr = (cnt == CNT_W'(WR_LEN));
    len_rd = (cnt == CNT_W'(RD_LEN));
    par_wr = ^sr;
    par_rd = ^sr[WR_LEN-1:RD_BASE];
    cmd.wr   = upd && len_wr && sr[FLAG_POS] && par_wr;
    cmd.rd   = upd && len_rd && !sr[FLAG_POS] && par_rd;
    cmd.addr = sr[DW +: AW];
    cmd.data = sr[DW-1:0];
  end
endmodule

// File: rtl/jub_result.sv
module jub_result
  import jub_pkg::*;
(
  input  logic          tck,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [DW-1:0] result_word
);
  logic          pend;
  logic [DW-1:0] held;
  logic          acc;

  assign in_ready    = !pend || pop;
  assign acc         = in_valid && in_ready;
  assign result_word = pend ? held : '1;

  always_ff @(posedge tck) begin
    if (!rst_n) begin
      pend <= 1'b0;
      held <= '0;
    end else if (acc) begin
      pend <= 1'b1;
      held <= in_data;
    end else if (pop) begin
      pend <= 1'b0;
    end
  end

  // R8
  keep_new_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (in_valid && pop) |=> (result_word == $past(in_data)));
  // R7
  pop_empty_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (pop && !in_valid) |=> (result_word == '1));
  // R8
  no_overwrite_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (pend && !pop) |=> $stable(held));
endmodule

// File: rtl/jub_regbank.sv
module jub_regbank
  import jub_pkg::*;
(
  input  logic                 tck,
  input  logic                 rst_n,
  input  cmd_t                 cmd,
  input  logic [DW-1:0]        result_word,
  output logic [N_MID*DW-1:0]  midstate,
  output logic [N_TAIL*DW-1:0] hdr_tail,
  output logic [DW-1:0]        clk_setting,
  output logic                 work_start,
  output logic [DW-1:0]        rd_word,
  output logic                 pop
);
  logic [DW-1:0] hdr [N_HDR];
  logic [DW-1:0] clk_q;
  logic [DW-1:0] mux_word;

  genvar gi;
  generate
    for (gi = 0; gi < N_HDR; gi++) begin : g_word
      always_ff @(posedge tck) begin
        if (!rst_n) hdr[gi] <= '0;
        else if (cmd.wr && cmd.addr == AW'(A_FIRST + gi)) hdr[gi] <= cmd.data;
      end
      if (gi < N_MID) begin : g_mid
        assign midstate[gi*DW +: DW] = hdr[gi];
      end else begin : g_tail
        assign hdr_tail[(gi-N_MID)*DW +: DW] = hdr[gi];
      end
    end
  endgenerate

  always_comb begin
    mux_word = '0;
    for (int k = 0; k < N_HDR; k++)
      if (cmd.addr == AW'(A_FIRST + k)) mux_word = hdr[k];
    if (cmd.addr == AW'(A_CLK)) mux_word = clk_q;
    if (cmd.addr == AW'(A_RES)) mux_word = result_word;
  end

  assign pop         = cmd.rd && cmd.addr == AW'(A_RES);
  assign clk_setting = clk_q;

  always_ff @(posedge tck) begin
    if (!rst_n) begin
      clk_q      <= '0;
      rd_word    <= '0;
      work_start <= 1'b0;
    end else begin
      if (cmd.wr && cmd.addr == AW'(A_CLK)) clk_q <= cmd.data;
      if (cmd.rd) rd_word <= mux_word;
      work_start <= cmd.wr && cmd.addr == AW'(A_START);
    end
  end

  // R9
  start_pulse_chk: assert property (@(posedge tck) disable iff (!rst_n)
    work_start |=> !work_start);
  // R6
  clk_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !(cmd.wr && cmd.addr == AW'(A_CLK)) |=> $stable(clk_q));
  // R2
  latch_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !cmd.rd |=> $stable(rd_word));
endmodule

// File: rtl/jtag_reg_bridge.sv
module jtag_reg_bridge
  import jub_pkg::*;
(
  input  logic                 tck,
  input  logic                 rst_n,
  input  logic                 usr_sel,
  input  logic                 capture_dr,
  input  logic                 shift_dr,
  input  logic                 update_dr,
  input  logic                 tdi,
  output logic                 tdo,
  input  logic                 nonce_valid,
  input  logic [DW-1:0]        nonce_data,
  output logic                 nonce_ready,
  output logic [N_MID*DW-1:0]  midstate,
  output logic [N_TAIL*DW-1:0] hdr_tail,
  output logic [DW-1:0]        clk_setting,
  output logic                 work_start
);
  logic              cap, sft, upd;
  logic [WR_LEN-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     rd_word, result_word;
  logic              pop;
  cmd_t              cmd;

  assign cap = usr_sel && capture_dr;
  assign sft = usr_sel && shift_dr;
  assign upd = usr_sel && update_dr;

  jub_shifter u_shift (
    .tck(tck), .rst_n(rst_n), .cap(cap), .sft(sft), .upd(upd), .tdi(tdi),
    .load_word(rd_word), .sr(sr), .cnt(cnt), .tdo(tdo)
  );

  jub_decode u_dec (.upd(upd), .sr(sr), .cnt(cnt), .cmd(cmd));

  jub_regbank u_bank (
    .tck(tck), .rst_n(rst_n), .cmd(cmd), .result_word(result_word),
    .midstate(midstate), .hdr_tail(hdr_tail), .clk_setting(clk_setting),
    .work_start(work_start), .rd_word(rd_word), .pop(pop)
  );

  jub_result u_res (
    .tck(tck), .rst_n(rst_n), .pop(pop), .in_valid(nonce_valid),
    .in_data(nonce_data), .in_ready(nonce_ready), .result_word(result_word)
  );

  // R1
  one_cmd_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !(cmd.wr && cmd.rd));
  // R11
  sel_gate_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !usr_sel |=> $stable(sr));
  // R3
  cap_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    cap |=> (sr[DW-1:0] == $past(rd_word)));
endmodule

// File: tb/tb_jtag_reg_bridge.sv
module tb_jtag_reg_bridge;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic usr_sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic nonce_valid = 1'b0;
  logic [31:0] nonce_data = '0;
  logic nonce_ready;
  logic [255:0] midstate;
  logic [95:0]  hdr_tail;
  logic [31:0]  clk_setting;
  logic work_start;

  int checks = 0, errors = 0;
  logic [31:0] m [16];
  logic pend_m = 1'b0;
  logic [31:0] nonce_m = '0;
  logic [31:0] latch_m = '0;
  logic inj_en = 1'b0;
  logic [31:0] inj_val = '0;
  logic seen_ws;

  jtag_reg_bridge dut (.*);

  always #5 tck = ~tck;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected end");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [37:0] mk_wr(input int a, input logic [31:0] d, input bit bad);
    logic [37:0] f;
    f[31:0] = d; f[35:32] = 4'(a); f[36] = 1'b1;
    f[37] = ~^f[36:0];
    if (bad) f[37] = ~f[37];
    return f;
  endfunction

  function automatic logic [37:0] mk_rd(input int a);
    logic [37:0] f = '0;
    f[3:0] = 4'(a); f[4] = 1'b0; f[5] = ~^f[4:0];
    return f;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    if (a >= 1 && a <= 11) return m[a];
    if (a == 13) return m[13];
    if (a == 14) return pend_m ? nonce_m : 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  // shift n bits of f, then update; samples work_start the cycle after update
  task automatic scan(input logic [37:0] f, input int n);
    @(negedge tck) capture_dr = 1'b1;
    @(negedge tck) capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = f[i];
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    if (inj_en) begin nonce_valid = 1'b1; nonce_data = inj_val; end
    #1;
    if (inj_en) chk("R8 ready during pop", 256'(nonce_ready), 256'(1));
    @(negedge tck) update_dr = 1'b0; nonce_valid = 1'b0;
    seen_ws = work_start;
  endtask

  task automatic read_word(output logic [31:0] w);
    @(negedge tck) capture_dr = 1'b1;
    @(negedge tck) capture_dr = 1'b0;
    for (int i = 0; i < 32; i++) begin
      w[i] = tdo;
      shift_dr = 1'b1; tdi = 1'b0;
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck) update_dr = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input bit bad);
    scan(mk_wr(a, d, bad), 38);
    chk("R9 start pulse", 256'(seen_ws), 256'(!bad && a == 11));
    @(negedge tck);
    chk("R9 pulse ends", 256'(work_start), 256'(0));
    if (!bad && ((a >= 1 && a <= 11) || a == 13)) m[a] = d;
  endtask

  task automatic do_read(input int a, input string req);
    logic [31:0] w;
    latch_m = exp_read(a);
    scan(mk_rd(a), 6);
    if (a == 14) begin
      if (inj_en) begin pend_m = 1'b1; nonce_m = inj_val; end
      else pend_m = 1'b0;
    end
    read_word(w);
    chk(req, 256'(w), 256'(latch_m));
  endtask

  task automatic push_nonce(input logic [31:0] v);
    @(negedge tck) nonce_valid = 1'b1; nonce_data = v;
    #1 chk("R8 ready level", 256'(nonce_ready), 256'(!pend_m));
    if (!pend_m) begin pend_m = 1'b1; nonce_m = v; end
    @(negedge tck) nonce_valid = 1'b0;
  endtask

  task automatic chk_outs();
    logic [255:0] em; logic [95:0] et;
    for (int k = 0; k < 8; k++) em[32*k +: 32] = m[k+1];
    for (int k = 0; k < 3; k++) et[32*k +: 32] = m[9+k];
    chk("R5 midstate", midstate, em);
    chk("R5 hdr_tail", 256'(et), 256'(et == hdr_tail ? hdr_tail : et));
    chk("R5 hdr_tail value", 256'(hdr_tail), 256'(et));
    chk("R6 clk_setting", 256'(clk_setting), 256'(m[13]));
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) m[k] = '0;
    repeat (3) @(negedge tck);
    rst_n = 1'b1; usr_sel = 1'b1;
    @(negedge tck);
    // R12 reset state
    chk("R12 tdo", 256'(tdo), 256'(0));
    chk("R12 work_start", 256'(work_start), 256'(0));
    chk("R12 nonce_ready", 256'(nonce_ready), 256'(1));
    chk_outs();
    do_read(14, "R12 R7 empty result");

    // R1 R6 directed
    do_write(13, 32'd180, 1'b0);
    do_read(13, "R6 clk readback");
    do_write(11, 32'hCAFE_0011, 1'b0);
    do_write(1, 32'h0000_0001, 1'b0);
    do_write(8, 32'h8000_0000, 1'b0);
    chk_outs();

    // R2 bad parity keeps latch and regs
    scan(mk_rd(8), 6);
    latch_m = m[8];
    do_write(8, 32'h1234_5678, 1'b1);
    read_word(w);
    chk("R2 latch and reg kept", 256'(w), 256'(m[8]));

    // R4 wrong lengths / flags
    scan(mk_wr(2, 32'hDEAD_BEEF, 1'b0), 37);
    begin
      logic [37:0] f = mk_wr(3, 32'hBEEF_0003, 1'b0);
      f[36] = 1'b0; f[37] = ~^f[36:0];
      scan(f, 38);
      f = mk_rd(1); f[4] = 1'b1; f[5] = ~^f[4:0];
      scan(f, 6);
    end
    do_read(2, "R4 37-bit dropped");
    do_read(3, "R4 flag-0 38-bit dropped");

    // R10 unlisted and result writes ignored
    do_write(0, 32'h1111_1111, 1'b0);
    do_write(12, 32'h2222_2222, 1'b0);
    do_write(15, 32'h3333_3333, 1'b0);
    do_write(14, 32'h4444_4444, 1'b0);
    do_read(0, "R10 reg0 zero");
    do_read(15, "R10 reg15 zero");
    do_read(14, "R10 result not written");

    // R11 select low
    usr_sel = 1'b0;
    scan(mk_wr(4, 32'h5555_AAAA, 1'b0), 38);
    usr_sel = 1'b1;
    do_read(4, "R11 ignored without select");

    // R7 R8 result slot
    push_nonce(32'h0BAD_F00D);
    push_nonce(32'h0000_0042);
    inj_en = 1'b1; inj_val = 32'h7777_0001;
    do_read(14, "R7 first nonce, R8 refill");
    inj_en = 1'b0;
    do_read(14, "R8 kept refill");
    do_read(14, "R7 empty after pop");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int a = int'($urandom_range(15, 0));
      do_write(a, $urandom(), ($urandom_range(7, 0) == 0));
      chk_outs();
      if ($urandom_range(3, 0) == 0) push_nonce($urandom());
      do_read(int'($urandom_range(15, 0)), "R1 R3 random readback");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule